// File: doc/BRIEF.md
# Multi-Mode Up/Down Timer Counter

This block is a 16-bit timer counter driven by a small register bus. Software picks one of four counting modes through a control register. In the edge-aligned mode the counter runs in one direction, set by a direction bit. In the three centre-aligned modes the counter climbs and then falls, again and again. Each turnaround or wrap raises a one-cycle update pulse. At that pulse a buffered reload value can take effect, and a one-pulse setting can stop the counter.

One compare channel watches the count. Its sticky flag is set on a match, but only in the count directions that the selected mode allows. Software clears the flag by writing zero to it. The counter value can be read over the bus and also loaded from it.

Top module: `updown_timer`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000, the count (address 3), compare value (address 2) and status (address 4) read 0, the reload value (address 1) reads 0xFFFF, and `run_o`, `update_o` and `cmp_flag_o` are low.
- R2: With mode field 00 and direction bit (bit 4) at 0, an enabled counter adds one per clock. From the reload value it goes to 0, and `update_o` is high during the cycle in which the count equals the reload value.
- R3: With mode field 00 and direction bit 1, the counter subtracts one per clock. From 0 it goes to the reload value, and `update_o` is high during the cycle in which the count is 0.
- R4: With mode field (bits 6:5) at 01, 10 or 11 and reload R ≥ 1, the counter steps 0,1,…,R−1, then R, R−1,…,1, then 0 again. `update_o` is high in the cycle before it reaches R and in the cycle before it reaches 0.
- R5: While running, the status flag (bit 0 at address 4, also `cmp_flag_o`) is set at the clock where the count equals the compare value. Values 0..R−1 count as rising and R..1 as falling. Mode 01 sets the flag only while falling, mode 10 only while rising, and modes 00 and 11 in any direction. The flag stays set until a write of 0 to bit 0; a write of 1 leaves it unchanged.
- R6: In a centre-aligned mode the direction bit reads 1 while falling and 0 while rising, and bus writes to it are ignored.
- R7: While enabled in mode 00, a control write asking for a non-zero mode leaves the mode at 00. The other fields of that write still apply.
- R8: With the reload-buffer bit (bit 7) at 0, a reload write takes effect on the next clock. With it at 1, the written value, which address 1 reads back, becomes active only at the next update pulse.
- R9: With the one-pulse bit (bit 3) set, the enable bit (bit 0, also `run_o`) clears at the update pulse, and the count then holds.
- R10: Bits 15:8 and 2:1 of the control word always read 0.
- R11: A write to address 3 loads the count and takes precedence over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| run_o | output | 1 | Counter enable bit |
| update_o | output | 1 | Update pulse, high in the cycle before a wrap or turnaround |
| cmp_flag_o | output | 1 | Sticky compare flag |

## Verification
The hardest case to reach is the direction-gated compare flag. It depends on reaching a given count value while the counter is on one particular leg of a centre-aligned cycle. The stimulus places the compare value part way up the ramp and runs several full up/down cycles in each centre-aligned mode. It clears the flag between modes, so that a set on the wrong leg shows up. The protected direction bit and the blocked mode change are reached by issuing control writes while the counter is running, and then reading the control word back.

// File: rtl/updown_timer_pkg.sv
// Package: shared register addresses, control-bit positions and the mode type
// for the multi-mode timer. Assumes a counter/data width of at least 8 bits.
package updown_timer_pkg;

    localparam int UTC_A_CTRL   = 0;
    localparam int UTC_A_RELOAD = 1;
    localparam int UTC_A_CMP    = 2;
    localparam int UTC_A_COUNT  = 3;
    localparam int UTC_A_STATUS = 4;

    localparam int UTC_B_EN   = 0;
    localparam int UTC_B_OPM  = 3;
    localparam int UTC_B_DIR  = 4;
    localparam int UTC_B_MODE = 5;
    localparam int UTC_B_PRE  = 7;

    typedef enum logic [1:0] {
        UTC_EDGE     = 2'b00,
        UTC_CTR_DOWN = 2'b01,
        UTC_CTR_UP   = 2'b10,
        UTC_CTR_BOTH = 2'b11
    } utc_mode_t;

endpackage

// File: rtl/utc_ctrl_reg.sv
// Control register: enable, one-pulse, direction, mode and reload-buffer bits.
// Assumes field values arrive already split from the bus word. The direction
// bit is owned by the counter while a centre-aligned mode is active.
module utc_ctrl_reg
    import updown_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic      w_en,
    input  logic      w_opm,
    input  logic      w_dir,
    input  logic [1:0] w_mode,
    input  logic      w_pre,
    input  logic      upd,
    output logic      en,
    output logic      opm,
    output logic      dir,
    output utc_mode_t mode,
    output logic      pre,
    output logic [W-1:0] rd
);

    logic center;
    logic mode_lock;

    assign center    = (mode != UTC_EDGE);
    assign mode_lock = en && !center && (w_mode != 2'b00);

    // Purpose: register updates from the bus, one-pulse stop and direction tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            opm  <= 1'b0;
            dir  <= 1'b0;
            mode <= UTC_EDGE;
            pre  <= 1'b0;
        end else begin
            if (wr) begin
                en  <= w_en;
                opm <= w_opm;
                pre <= w_pre;
                if (!mode_lock) begin
                    mode <= utc_mode_t'(w_mode);
                end
            end
            if (upd && opm) begin
                en <= 1'b0;
            end
            if (center) begin
                if (upd) begin
                    dir <= ~dir;
                end
            end else if (wr) begin
                dir <= w_dir;
            end
        end
    end

    // Purpose: assemble the read-back word with unused bits held at zero.
    always_comb begin
        rd               = '0;
        rd[UTC_B_EN]     = en;
        rd[UTC_B_OPM]    = opm;
        rd[UTC_B_DIR]    = dir;
        rd[UTC_B_MODE+:2] = mode;
        rd[UTC_B_PRE]    = pre;
    end

endmodule

// File: rtl/utc_reload.sv
// Reload storage: a bus-visible buffer and the active value used by the counter.
// With buffering off both change together. With it on, the active copy
// follows the buffer only at an update pulse.
module utc_reload #(
    parameter int             W   = 16,
    parameter logic [W-1:0]   RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         pre,
    input  logic         upd,
    output logic [W-1:0] active,
    output logic [W-1:0] buffered
);

    // Purpose: capture bus writes and transfer the buffer on update pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= RST;
            buffered <= RST;
        end else begin
            if (wr) begin
                buffered <= wdata;
            end
            if (wr && !pre) begin
                active <= wdata;
            end else if (upd && pre) begin
                active <= buffered;
            end
        end
    end

endmodule

// File: rtl/utc_count_core.sv
// Count core: computes the next count, wrap/turnaround detection and the
// update pulse for edge-aligned and centre-aligned counting. A reload of 0
// in a centre-aligned mode parks the count at 0 with no update.
module utc_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         center,
    input  logic         dir,
    input  logic [W-1:0] reload,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         upd
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] nxt;
    logic         wrap;

    // Purpose: next-count and boundary detection for the current mode and direction.
    always_comb begin
        nxt  = cnt;
        wrap = 1'b0;
        if (!center) begin
            if (!dir) begin
                wrap = (cnt == reload);
                nxt  = wrap ? '0 : cnt + ONE;
            end else begin
                wrap = (cnt == '0);
                nxt  = wrap ? reload : cnt - ONE;
            end
        end else if (reload != '0) begin
            if (!dir) begin
                wrap = (cnt >= reload - ONE);
                nxt  = wrap ? reload : cnt + ONE;
            end else begin
                wrap = (cnt <= ONE);
                nxt  = wrap ? '0 : cnt - ONE;
            end
        end else begin
            nxt = '0;
        end
    end

    assign upd = en && wrap;

    // Purpose: count register, with bus loads taking precedence over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (en) begin
            cnt <= nxt;
        end
    end

endmodule

// File: rtl/utc_compare.sv
// Compare channel: holds the compare value and a sticky match flag. Whether
// a match counts depends on the mode and the current count direction.
module utc_compare
    import updown_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_val,
    input  logic         wr_stat,
    input  logic [W-1:0] wdata,
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  utc_mode_t    mode,
    input  logic         dir,
    output logic [W-1:0] ccr,
    output logic         flag
);

    logic gate;
    logic hit;

    // Purpose: allow a match only in the directions the mode permits.
    always_comb begin
        unique case (mode)
            UTC_CTR_DOWN: gate = dir;
            UTC_CTR_UP:   gate = !dir;
            default:      gate = 1'b1;
        endcase
    end

    assign hit = en && gate && (cnt == ccr);

    // Purpose: compare value storage and sticky flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr  <= '0;
            flag <= 1'b0;
        end else begin
            if (wr_val) begin
                ccr <= wdata;
            end
            if (hit) begin
                flag <= 1'b1;
            end else if (wr_stat && !wdata[0]) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/updown_timer.sv
// Top: register decode and read-back for the multi-mode up/down timer.
// Assumes single-cycle bus writes and combinational reads; unmapped
// addresses read as zero and ignore writes.
module updown_timer
    import updown_timer_pkg::*;
#(
    parameter int                 CNT_W      = 16,
    parameter int                 ADDR_W     = 3,
    parameter logic [CNT_W-1:0]   RELOAD_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              run_o,
    output logic              update_o,
    output logic              cmp_flag_o
);

    logic             wr_ctrl, wr_reload, wr_cmp, wr_count, wr_stat;
    logic             en_q, opm_q, dir_q, pre_q, upd;
    utc_mode_t        mode_q;
    logic [CNT_W-1:0] ctrl_rd, reload_act, reload_buf, cmp_q, count_q;
    logic             flag_q;

    // Purpose: decode bus writes per register.
    always_comb begin
        wr_ctrl   = bus_we && (bus_addr == ADDR_W'(UTC_A_CTRL));
        wr_reload = bus_we && (bus_addr == ADDR_W'(UTC_A_RELOAD));
        wr_cmp    = bus_we && (bus_addr == ADDR_W'(UTC_A_CMP));
        wr_count  = bus_we && (bus_addr == ADDR_W'(UTC_A_COUNT));
        wr_stat   = bus_we && (bus_addr == ADDR_W'(UTC_A_STATUS));
    end

    utc_ctrl_reg #(.W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ctrl),
        .w_en   (bus_wdata[UTC_B_EN]),
        .w_opm  (bus_wdata[UTC_B_OPM]),
        .w_dir  (bus_wdata[UTC_B_DIR]),
        .w_mode (bus_wdata[UTC_B_MODE+:2]),
        .w_pre  (bus_wdata[UTC_B_PRE]),
        .upd    (upd),
        .en     (en_q),
        .opm    (opm_q),
        .dir    (dir_q),
        .mode   (mode_q),
        .pre    (pre_q),
        .rd     (ctrl_rd)
    );

    utc_reload #(.W(CNT_W), .RST(RELOAD_RST)) u_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_reload),
        .wdata    (bus_wdata),
        .pre      (pre_q),
        .upd      (upd),
        .active   (reload_act),
        .buffered (reload_buf)
    );

    utc_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .center   (mode_q != UTC_EDGE),
        .dir      (dir_q),
        .reload   (reload_act),
        .load     (wr_count),
        .load_val (bus_wdata),
        .cnt      (count_q),
        .upd      (upd)
    );

    utc_compare #(.W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_val  (wr_cmp),
        .wr_stat (wr_stat),
        .wdata   (bus_wdata),
        .en      (en_q),
        .cnt     (count_q),
        .mode    (mode_q),
        .dir     (dir_q),
        .ccr     (cmp_q),
        .flag    (flag_q)
    );

    // Purpose: read-back multiplexer.
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(UTC_A_CTRL):   bus_rdata = ctrl_rd;
            ADDR_W'(UTC_A_RELOAD): bus_rdata = reload_buf;
            ADDR_W'(UTC_A_CMP):    bus_rdata = cmp_q;
            ADDR_W'(UTC_A_COUNT):  bus_rdata = count_q;
            ADDR_W'(UTC_A_STATUS): bus_rdata = {{(CNT_W-1){1'b0}}, flag_q};
            default:               bus_rdata = '0;
        endcase
    end

    assign run_o      = en_q;
    assign update_o   = upd;
    assign cmp_flag_o = flag_q;

endmodule

// File: rtl/utc_checker.sv
// Checker: temporal properties of the timer, bound into the top module.
module utc_checker #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic              run,
    input logic              upd,
    input logic              flag,
    input logic [CNT_W-1:0]  cnt,
    input logic [1:0]        mode,
    input logic              dir,
    input logic              opm
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R9: one-pulse mode stops the counter at the update pulse
    a_r9_opm_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (run && opm && upd) |=> !run);

    // R5: the flag only falls on a clearing write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_we && bus_addr == ADDR_W'(4) && !wbit0)) |=> flag);

    // R7: a running edge-aligned counter cannot enter a centre-aligned mode
    a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == 2'b00) |=> (mode == 2'b00));

    // R4: update pulses only while running
    a_r4_update_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> run);

    // R2: edge-aligned up counting advances by one away from the wrap
    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == 2'b00 && !dir && !upd && !(bus_we && bus_addr == ADDR_W'(3)))
        |=> (cnt == $past(cnt) + ONE));

    // R6: in centre-aligned modes direction changes only at a turnaround
    a_r6_dir_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !upd) |=> (dir == $past(dir)));

endmodule

bind updown_timer utc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wbit0    (bus_wdata[0]),
    .run      (run_o),
    .upd      (update_o),
    .flag     (cmp_flag_o),
    .cnt      (count_q),
    .mode     (mode_q),
    .dir      (dir_q),
    .opm      (opm_q)
);

// File: tb/updown_timer_bench.sv
// Bench: behavioural reference model of the timer, compared on every clock.
module updown_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        run_o, update_o, cmp_flag_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    int m_cnt, m_en, m_opm, m_dir, m_mode, m_pre, m_sh, m_act, m_ccr, m_flag;

    always #4 clk = ~clk;

    updown_timer u_updown_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_o(run_o),
        .update_o(update_o), .cmp_flag_o(cmp_flag_o)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 100000)", cycles);
            finish_run();
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, compare against the model, then advance the model.
    task automatic cyc(input bit we, input int a, input int wd);
        int nxt, rd, n_cnt, n_en, n_mode, n_dir, n_act;
        bit wrap, upd, center, gate, hit;
        @(negedge clk);
        bus_we = we; bus_addr = a[2:0]; bus_wdata = wd[15:0];
        #1;
        center = (m_mode != 0);
        wrap = 0; nxt = m_cnt;
        if (!center) begin
            if (m_dir == 0) begin wrap = (m_cnt == m_act); nxt = wrap ? 0 : (m_cnt + 1) & 16'hFFFF; end
            else begin wrap = (m_cnt == 0); nxt = wrap ? m_act : m_cnt - 1; end
        end else if (m_act != 0) begin
            if (m_dir == 0) begin wrap = (m_cnt >= m_act - 1); nxt = wrap ? m_act : m_cnt + 1; end
            else begin wrap = (m_cnt <= 1); nxt = wrap ? 0 : m_cnt - 1; end
        end else nxt = 0;
        upd = (m_en != 0) && wrap;
        case (a)
            0: rd = (m_pre << 7) | (m_mode << 5) | (m_dir << 4) | (m_opm << 3) | m_en;
            1: rd = m_sh;
            2: rd = m_ccr;
            3: rd = m_cnt;
            4: rd = m_flag;
            default: rd = 0;
        endcase
        chk(phase, $sformatf("read addr %0d", a), bus_rdata, rd);
        chk(phase, "update_o", update_o, upd);
        chk(phase, "run_o", run_o, m_en);
        chk("R5", "cmp_flag_o", cmp_flag_o, m_flag);
        gate = (m_mode == 1) ? (m_dir == 1) : (m_mode == 2) ? (m_dir == 0) : 1'b1;
        hit = (m_en != 0) && gate && (m_cnt == m_ccr);
        n_cnt = (we && a == 3) ? wd : (m_en != 0) ? nxt : m_cnt;
        n_en = (we && a == 0) ? (wd & 1) : m_en;
        if (upd && m_opm != 0) n_en = 0;
        n_mode = m_mode;
        if (we && a == 0 && !(m_en != 0 && m_mode == 0 && ((wd >> 5) & 3) != 0)) n_mode = (wd >> 5) & 3;
        n_dir = m_dir;
        if (center) begin if (upd) n_dir = 1 - m_dir; end
        else if (we && a == 0) n_dir = (wd >> 4) & 1;
        n_act = m_act;
        if (we && a == 1 && m_pre == 0) n_act = wd;
        else if (upd && m_pre != 0) n_act = m_sh;
        @(posedge clk);
        m_cnt = n_cnt; m_en = n_en; m_mode = n_mode; m_dir = n_dir; m_act = n_act;
        if (we && a == 0) begin m_opm = (wd >> 3) & 1; m_pre = (wd >> 7) & 1; end
        if (we && a == 1) m_sh = wd;
        if (we && a == 2) m_ccr = wd;
        if (hit) m_flag = 1;
        else if (we && a == 4 && (wd & 1) == 0) m_flag = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3, 0);
    endtask

    task automatic wr(input int a, input int d);
        cyc(1, a, d);
    endtask

    initial begin
        m_cnt = 0; m_en = 0; m_opm = 0; m_dir = 0; m_mode = 0; m_pre = 0;
        m_sh = 16'hFFFF; m_act = 16'hFFFF; m_ccr = 0; m_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        phase = "R1";
        for (int a = 0; a < 5; a++) cyc(0, a, 0);

        phase = "R10";
        wr(0, 16'hFF06); cyc(0, 0, 0);

        phase = "R2";
        wr(1, 4); cyc(0, 1, 0);
        wr(0, 1); idle(14);

        phase = "R11";
        wr(3, 2); idle(4); wr(3, 16'h0100); idle(3);

        phase = "R3";
        wr(0, 0); wr(3, 3); wr(0, 1 | (1 << 4)); idle(14);

        phase = "R4";
        wr(0, 0); wr(3, 0); wr(2, 2); wr(4, 0);
        wr(0, 1 | (3 << 5)); idle(20);

        phase = "R5";
        wr(0, 0); wr(3, 0); wr(4, 0);
        wr(0, 1 | (1 << 5)); idle(2); idle(3); idle(12);
        wr(0, 0); wr(4, 0); wr(3, 3); wr(0, 1 | (2 << 5) | (1 << 4)); idle(5);
        wr(0, 0); wr(4, 0); wr(3, 0); wr(0, 1 | (2 << 5)); idle(12);
        wr(4, 1); idle(2); wr(4, 0); idle(3);
        wr(0, 0); wr(4, 0); wr(3, 0); wr(0, 1); idle(10);

        phase = "R6";
        wr(0, 0); wr(3, 0); wr(0, 1 | (3 << 5));
        for (int i = 0; i < 10; i++) cyc(0, 0, 0);
        wr(0, 1 | (3 << 5) | (1 << 4)); cyc(0, 0, 0); idle(2);
        wr(0, 1 | (3 << 5) | (1 << 4)); idle(5);
        wr(0, 1 | (3 << 5)); cyc(0, 0, 0); idle(3); cyc(0, 0, 0);

        phase = "R7";
        wr(0, 0); wr(0, 1); idle(2);
        wr(0, 1 | (3 << 5) | (1 << 3)); cyc(0, 0, 0);
        wr(0, 0); wr(0, 1 | (2 << 5)); cyc(0, 0, 0); idle(3);

        phase = "R8";
        wr(0, 0); wr(3, 0); wr(1, 5); idle(1); wr(1, 4);
        wr(0, 1 | (1 << 7)); idle(2);
        wr(1, 7); cyc(0, 1, 0); idle(14);

        phase = "R9";
        wr(0, 0); wr(3, 0); wr(1, 3);
        wr(0, 1 | (1 << 3)); idle(8);
        wr(3, 2); wr(0, 1 | (1 << 3) | (1 << 4)); idle(6);

        finish_run();
    end

endmodule